// File: doc/BRIEF.md
# Vectored interrupt controller

The controller collects 32 level-sensitive interrupt requests and sorts each one into one of three classes under software control: fast interrupts, vectored IRQs and non-vectored IRQs. It drives two request lines to a processor. `fiq_o` carries the fast class. `irq_o` carries everything else.

Sixteen priority slots can each be pointed at any of the 32 sources. Each slot holds its own handler address. Any IRQ-routed source that no enabled slot claims falls back to a shared default handler address. Software reads the vector register to learn which handler to run.

That read also locks the priority logic at the level being served. While the lock is held, the served slot, every lower slot and all non-vectored sources stay off `irq_o`, and higher slots can still interrupt. A write to the vector register releases the lock.

The lock is a two-state machine, `LK_IDLE` and `LK_SERVICE`, with a lock level beside it. It has four transitions:
- **take**: `LK_IDLE` to `LK_SERVICE`, on a vector read while `irq_o` is high.
- **deepen**: `LK_SERVICE` to `LK_SERVICE`, on a vector read while a higher request holds `irq_o` high. The lock level moves up to that request.
- **release**: `LK_SERVICE` to `LK_IDLE`, on a write to the vector register.
- **hold**: the machine stays where it is in every other cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `fiq_o` and `irq_o` are low, and every register reads 0, the vector register included.
- R2: A request whose enable bit is 0 has no effect on `fiq_o` or `irq_o`.
- R3: `fiq_o` is the OR of all requests that are active, enabled and have their select bit set to 1. A held lock never affects it. A request with select bit 0 reaches only `irq_o`.
- R4: A slot control register reads back its low 6 bits. Bit 5 enables the slot and bits 4:0 name the source it serves, so 0x2E serves source 14.
- R5: A vector read returns the handler address of the lowest-numbered enabled slot whose source is active, enabled and IRQ-routed.
- R6: An active, enabled, IRQ-routed source that no enabled slot claims raises `irq_o`, and a vector read then returns the default address. When nothing is pending, a vector read also returns the default address.
- R7: A vector read while `irq_o` is high locks at the level served. From then on that slot, all lower slots and all non-vectored sources are kept off `irq_o`. A default-address read locks out only the non-vectored sources.
- R8: While the lock is held, an active higher-priority slot still raises `irq_o`. Reading the vector register then returns that slot's address and moves the lock up to it.
- R9: A write to the vector register releases the lock, so every pending request drives `irq_o` again.
- R10: The register file uses word addresses:
  - enable at 0x00 and select at 0x01, one bit per source;
  - default address at 0x02;
  - vector register at 0x03;
  - slot n control at 0x10+n;
  - slot n address at 0x20+n.
  Unmapped addresses read 0.
- R11: A slot never wins when its control bit 5 is 0 or when its source is routed to the fast class. A source whose slot is disabled counts as non-vectored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 32 | Level-sensitive interrupt requests |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; a read of the vector register takes the lock at the clock edge |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The hardest case to reach is a higher-priority slot arriving while a lower level is already in service, because the arrival must land on an existing lock. To get there, the stimulus takes the lock with a vector read on a middle slot, then raises lower, non-vectored and higher requests one at a time, checking `irq_o` after each step. A second vector read then deepens the lock, and a write releases it. The default-address lock gets the same treatment: only an unclaimed source is raised first, and a vectored one is added afterwards.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    typedef enum logic [0:0] {
        LK_IDLE    = 1'b0,
        LK_SERVICE = 1'b1
    } lock_state_e;

    localparam int ADR_ENABLE  = 'h00;
    localparam int ADR_SELECT  = 'h01;
    localparam int ADR_DEFAULT = 'h02;
    localparam int ADR_VECTOR  = 'h03;
    localparam int REGION_CTL  = 1;
    localparam int REGION_VAD  = 2;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs #(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 6,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CTL_W   = SRC_W + 1,
    localparam int SLOT_IW = $clog2(NUM_SLOT),
    localparam int RGN_W   = ADDR_W - SLOT_IW
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_SRC-1:0]               en_q,
    output logic [NUM_SRC-1:0]               sel_q,
    output logic [DATA_W-1:0]                def_q,
    output logic [NUM_SLOT-1:0][CTL_W-1:0]   ctl_q,
    output logic [NUM_SLOT-1:0][DATA_W-1:0]  vad_q
);
    import ivc_pkg::*;

    logic [RGN_W-1:0]   region;
    logic [SLOT_IW-1:0] slot_sel;

    assign region   = addr[ADDR_W-1:SLOT_IW];
    assign slot_sel = addr[SLOT_IW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
            def_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADR_ENABLE))  en_q  <= wdata[NUM_SRC-1:0];
            if (addr == ADDR_W'(ADR_SELECT))  sel_q <= wdata[NUM_SRC-1:0];
            if (addr == ADDR_W'(ADR_DEFAULT)) def_q <= wdata;
        end
    end

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q[s] <= '0;
                vad_q[s] <= '0;
            end else if (wr_en && slot_sel == SLOT_IW'(s)) begin
                if (region == RGN_W'(REGION_CTL)) ctl_q[s] <= wdata[CTL_W-1:0];
                if (region == RGN_W'(REGION_VAD)) vad_q[s] <= wdata;
            end
        end
    end
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CTL_W   = SRC_W + 1,
    localparam int SLOT_IW = $clog2(NUM_SLOT),
    localparam int LVL_W   = $clog2(NUM_SLOT + 2)
) (
    input  logic [NUM_SRC-1:0]              irq_src,
    input  logic [NUM_SLOT-1:0][CTL_W-1:0]  ctl_q,
    input  logic [LVL_W-1:0]                lock_lvl,
    output logic                            slot_hit,
    output logic [SLOT_IW-1:0]              win_idx,
    output logic                            nv_pend
);
    logic [NUM_SLOT-1:0] slot_ok;
    logic [NUM_SRC-1:0]  claimed;

    // Per-slot match: enabled, source pending, above the lock level.
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_match
        assign slot_ok[s] = ctl_q[s][SRC_W]
                          && irq_src[ctl_q[s][SRC_W-1:0]]
                          && (LVL_W'(s) < lock_lvl);
    end

    always_comb begin
        claimed = '0;
        for (int s = 0; s < NUM_SLOT; s++) begin
            if (ctl_q[s][SRC_W]) claimed[ctl_q[s][SRC_W-1:0]] = 1'b1;
        end
    end

    always_comb begin
        win_idx = '0;
        for (int s = NUM_SLOT - 1; s >= 0; s--) begin
            if (slot_ok[s]) win_idx = SLOT_IW'(s);
        end
    end

    assign slot_hit = |slot_ok;
    assign nv_pend  = (|(irq_src & ~claimed)) && (lock_lvl > LVL_W'(NUM_SLOT));
endmodule

// File: rtl/ivc_lock.sv
module ivc_lock #(
    parameter int NUM_SLOT = 16,
    localparam int SLOT_IW = $clog2(NUM_SLOT),
    localparam int LVL_W   = $clog2(NUM_SLOT + 2),
    localparam int LVL_FREE = NUM_SLOT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vect_rd,
    input  logic               vect_wr,
    input  logic               irq_now,
    input  logic               slot_hit,
    input  logic [SLOT_IW-1:0] win_idx,
    output logic [LVL_W-1:0]   lock_lvl
);
    import ivc_pkg::*;

    lock_state_e state, state_nxt;
    logic        take;

    assign take = vect_rd && irq_now && !vect_wr;

    always_comb begin
        state_nxt = state;
        unique case (state)
            LK_IDLE:    if (take)    state_nxt = LK_SERVICE;
            LK_SERVICE: if (vect_wr) state_nxt = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_IDLE;
        else        state <= state_nxt;
    end

    // Lock level: LVL_FREE = nothing masked, NUM_SLOT = default in service.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lock_lvl <= LVL_W'(LVL_FREE);
        else if (vect_wr) lock_lvl <= LVL_W'(LVL_FREE);
        else if (take)    lock_lvl <= slot_hit ? LVL_W'(win_idx) : LVL_W'(NUM_SLOT);
    end

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vect_wr |=> (state == LK_IDLE && lock_lvl == LVL_W'(LVL_FREE)));

    assert_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state == LK_SERVICE));

    assert_deepen_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_SERVICE && !vect_wr) |=> (lock_lvl <= $past(lock_lvl)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 6,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CTL_W   = SRC_W + 1,
    localparam int SLOT_IW = $clog2(NUM_SLOT),
    localparam int LVL_W   = $clog2(NUM_SLOT + 2),
    localparam int RGN_W   = ADDR_W - SLOT_IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              fiq_o,
    output logic              irq_o
);
    import ivc_pkg::*;

    logic [NUM_SRC-1:0]              en_q, sel_q, irq_src;
    logic [DATA_W-1:0]               def_q, vect_val;
    logic [NUM_SLOT-1:0][CTL_W-1:0]  ctl_q;
    logic [NUM_SLOT-1:0][DATA_W-1:0] vad_q;
    logic [LVL_W-1:0]                lock_lvl;
    logic [SLOT_IW-1:0]              win_idx;
    logic                            slot_hit, nv_pend, vect_sel;
    logic [RGN_W-1:0]                region;

    ivc_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .en_q(en_q), .sel_q(sel_q), .def_q(def_q), .ctl_q(ctl_q), .vad_q(vad_q)
    );

    assign irq_src = req_i & en_q & ~sel_q;

    ivc_prio #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_prio (
        .irq_src(irq_src), .ctl_q(ctl_q), .lock_lvl(lock_lvl),
        .slot_hit(slot_hit), .win_idx(win_idx), .nv_pend(nv_pend)
    );

    assign vect_sel = (addr == ADDR_W'(ADR_VECTOR));

    ivc_lock #(.NUM_SLOT(NUM_SLOT)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .vect_rd(rd_en && vect_sel), .vect_wr(wr_en && vect_sel),
        .irq_now(irq_o), .slot_hit(slot_hit), .win_idx(win_idx),
        .lock_lvl(lock_lvl)
    );

    assign fiq_o    = |(req_i & en_q & sel_q);
    assign irq_o    = slot_hit || nv_pend;
    assign vect_val = slot_hit ? vad_q[win_idx] : def_q;
    assign region   = addr[ADDR_W-1:SLOT_IW];

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_ENABLE))        rdata[NUM_SRC-1:0] = en_q;
        else if (addr == ADDR_W'(ADR_SELECT))   rdata[NUM_SRC-1:0] = sel_q;
        else if (addr == ADDR_W'(ADR_DEFAULT))  rdata = def_q;
        else if (vect_sel)                      rdata = vect_val;
        else if (region == RGN_W'(REGION_CTL))  rdata[CTL_W-1:0] = ctl_q[addr[SLOT_IW-1:0]];
        else if (region == RGN_W'(REGION_VAD))  rdata = vad_q[addr[SLOT_IW-1:0]];
    end

    assert_win_above_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_hit |-> (LVL_W'(win_idx) < lock_lvl));

    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & en_q) == '0) |-> (!fiq_o && !irq_o));

    assert_fiq_routing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & en_q & sel_q) != '0) |-> fiq_o);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [31:0] DEF = 32'hDEF0_0000;
    localparam logic [31:0] A0  = 32'hA000_0000;
    localparam logic [31:0] A3  = 32'hA300_0000;
    localparam logic [31:0] A7  = 32'hA700_0000;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .fiq_o(fiq_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; #1;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0; #1;
    endtask

    task automatic set_req(input logic [31:0] v);
        @(negedge clk); req_i = v; #1;
    endtask

    task automatic release_lock();
        wr(6'h03, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 fiq", {31'b0, fiq_o}, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        rd(6'h00, d); check("R1 enable", d, 32'h0);
        rd(6'h12, d); check("R1 slot ctl", d, 32'h0);
        rd(6'h03, d); check("R1 vector", d, 32'h0);
    endtask

    task automatic t_enable_select();
        set_req(32'hFFFF_FFFF);
        check("R2 fiq gated", {31'b0, fiq_o}, 32'h0);
        check("R2 irq gated", {31'b0, irq_o}, 32'h0);
        wr(6'h00, 32'h0000_0008);
        check("R3 irq route", {31'b0, irq_o}, 32'h1);
        check("R3 fiq off", {31'b0, fiq_o}, 32'h0);
        wr(6'h01, 32'h0000_0008);
        check("R3 fiq route", {31'b0, fiq_o}, 32'h1);
        check("R3 irq off", {31'b0, irq_o}, 32'h0);
        set_req(32'h0);
        wr(6'h01, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(6'h1F, 32'hFFFF_FFFF);
        rd(6'h1F, d); check("R4 ctl low bits", d, 32'h3F);
        wr(6'h1F, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h02, DEF);
        wr(6'h10, 32'h25); wr(6'h20, A0);
        wr(6'h13, 32'h29); wr(6'h23, A3);
        wr(6'h17, 32'h2E); wr(6'h27, A7);
        rd(6'h17, d); check("R4 ctl readback", d, 32'h2E);
        rd(6'h23, d); check("R10 slot addr", d, A3);
        rd(6'h02, d); check("R10 default", d, DEF);
        rd(6'h3A, d); check("R10 unmapped", d, 32'h0);
    endtask

    task automatic t_vector();
        logic [31:0] d;
        set_req(32'h0000_4200);
        check("R5 irq", {31'b0, irq_o}, 32'h1);
        rd(6'h03, d); check("R5 slot3 wins", d, A3);
        release_lock();
        set_req(32'h0000_4000);
        rd(6'h03, d); check("R5 slot7", d, A7);
        release_lock();
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(6'h01, 32'h0000_0020);
        set_req(32'h0000_4020);
        check("R11 fiq from src5", {31'b0, fiq_o}, 32'h1);
        rd(6'h03, d); check("R11 fiq src skips slot0", d, A7);
        release_lock();
        wr(6'h01, 32'h0);
        wr(6'h17, 32'h0E);
        set_req(32'h0000_4000);
        check("R11 disabled slot irq", {31'b0, irq_o}, 32'h1);
        rd(6'h03, d); check("R11 disabled slot default", d, DEF);
        release_lock();
        wr(6'h17, 32'h2E);
    endtask

    task automatic t_default();
        logic [31:0] d;
        set_req(32'h0010_0000);
        check("R6 nonvec irq", {31'b0, irq_o}, 32'h1);
        rd(6'h03, d); check("R6 default vector", d, DEF);
        release_lock();
        set_req(32'h0);
        check("R6 idle irq", {31'b0, irq_o}, 32'h0);
        rd(6'h03, d); check("R6 idle default", d, DEF);
        set_req(32'h0000_0200);
        check("R6 no lock taken", {31'b0, irq_o}, 32'h1);
        set_req(32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        set_req(32'h0000_0200);
        rd(6'h03, d); check("R7 read slot3", d, A3);
        check("R7 served masked", {31'b0, irq_o}, 32'h0);
        set_req(32'h0010_4200);
        check("R7 lower and nonvec masked", {31'b0, irq_o}, 32'h0);
        wr(6'h01, 32'h4000_0000);
        set_req(32'h4010_4200);
        check("R3 fiq during lock", {31'b0, fiq_o}, 32'h1);
        wr(6'h01, 32'h0);
        set_req(32'h0010_4220);
        check("R8 higher asserts", {31'b0, irq_o}, 32'h1);
        rd(6'h03, d); check("R8 higher vector", d, A0);
        check("R8 deepened mask", {31'b0, irq_o}, 32'h0);
        release_lock();
        check("R9 release irq", {31'b0, irq_o}, 32'h1);
        rd(6'h03, d); check("R9 after release", d, A0);
        release_lock();
    endtask

    task automatic t_default_lock();
        logic [31:0] d;
        set_req(32'h0010_0000);
        rd(6'h03, d); check("R7 default read", d, DEF);
        check("R7 nonvec masked", {31'b0, irq_o}, 32'h0);
        set_req(32'h0010_4000);
        check("R8 slot over default", {31'b0, irq_o}, 32'h1);
        rd(6'h03, d); check("R8 slot7 vector", d, A7);
        release_lock();
        check("R9 pending again", {31'b0, irq_o}, 32'h1);
        set_req(32'h0);
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_enable_select();
        t_regmap();
        t_vector();
        t_ignored();
        t_default();
        t_lock();
        t_default_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule